// File: doc/BRIEF.md
# SPI Master Serial-Clock and Slave-Select Controller

This block is the timing half of an SPI master. It takes a reference clock and produces the serial clock, one active-low select line per slave, and two single-cycle strobes. The strobes tell the data path when to sample the incoming bit and when to shift out the next one. A 16-bit control word sets the clock divider, polarity, phase, the select pattern, and two mode bits: select hold and start gating. A separate one-bit enable register gates the whole controller.

The shift engine raises `tx_ready` when a word is waiting. The controller starts a word when it is enabled, set to master mode, and idle. If manual start gating is on, it also needs a `man_go` pulse. It then runs a fixed number of clock edges and reports the end of the word with `word_done`. Divider and phase are captured when a word starts, so software may rewrite them while a word is in flight.

Top module: `spi_sclk_cs_ctrl`

## Requirements
- R1: After reset, `sclk` is low, `busy`, `word_done` and both strobes are low, and all `ss_n` lines are high. The control word resets to 0 except bits 13:10, which reset to all ones. The enable register resets to 0.
- R2: Control bits 5:3 hold a divider code c. While a word runs, `sclk` toggles every 2^c reference cycles. Code 0 therefore divides by 2 and code 7 divides by 256.
- R3: When idle, `sclk` equals control bit 1 (polarity), one cycle after that bit is written. The first `sclk` edge comes 2^c cycles after the start edge.
- R4: A word is 2*WORD_BITS `sclk` edges and ends at the idle level. Every edge carries exactly one strobe in the same cycle. With control bit 2 (phase) at 0, odd-numbered edges (1st, 3rd, ...) give `sample_stb` and even-numbered edges give `shift_stb`. With phase at 1 the two are swapped.
- R5: Control bits 13:10 drive `ss_n[3:0]` directly, active low. When control bit 14 is 1, that pattern is held at all times. When bit 14 is 0, the pattern appears only while `busy` is high and every line is high otherwise.
- R6: When control bit 15 is 0, a word starts on the first edge at which the controller is idle and `tx_ready` is high. When bit 15 is 1, `man_go` must also be high on that edge.
- R7: While enable bit 0 is 0, no word starts and `sclk` sits at the idle level. Clearing the enable during a word aborts it on the next edge, without a `word_done` pulse.
- R8: Control bit 0 (master) must be 1 for a word to start.
- R9: A write to the divider or phase bits during a word has no effect on that word. It applies from the next word.
- R10: `word_done` pulses for one cycle, in the cycle `busy` falls after the final edge. The next word may start on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 1 | Enable register write data (bit 0) |
| tx_ready | input | 1 | Shift engine has a word to send |
| man_go | input | 1 | Manual start pulse |
| sclk | output | 1 | Serial clock |
| ss_n | output | 4 | Active-low slave selects |
| busy | output | 1 | A word is in progress |
| word_done | output | 1 | One-cycle end-of-word pulse |
| sample_stb | output | 1 | Sample the input bit this cycle |
| shift_stb | output | 1 | Shift out the next bit this cycle |

## Verification
The bench runs words at the slowest divider, the fastest divider and a middle divider, in each of the four polarity/phase combinations. This separates errors in the half-period count from errors in the mapping of strobes to edges. It holds `tx_ready` high with manual start gating on and then off, and with master mode or enable cleared, to show that each condition blocks a start on its own. It also rewrites the divider in the middle of a back-to-back word pair, which shows that the captured settings are separate from the live register. Finally, it switches select hold on and off, which shows held select patterns apart from patterns framed by `busy`.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int CTRL_W    = 16;
  localparam int SS_LO     = 10;
  localparam int SS_N      = 4;
  localparam int DIV_W     = 3;
  localparam int HALF_W    = 8;
  localparam int B_MASTER  = 0;
  localparam int B_POL     = 1;
  localparam int B_PHA     = 2;
  localparam int DIV_LO    = 3;
  localparam int B_HOLD_SS = 14;
  localparam int B_GATED   = 15;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(((1 << SS_N) - 1) << SS_LO);

  // Reference cycles per serial-clock half period for a divider code.
  function automatic logic [HALF_W-1:0] half_cycles(input logic [DIV_W-1:0] code);
    return HALF_W'(1) << code;
  endfunction
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CTRL_W-1:0]    cfg_wdata,
  input  logic                 en_wr,
  input  logic                 en_wdata,
  output logic                 enable,
  output logic                 master,
  output logic                 pol,
  output logic                 pha,
  output logic [DIV_W-1:0]     div_code,
  output logic [SS_N-1:0]      ss_field,
  output logic                 hold_ss,
  output logic                 gated_start
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              en_q;
  logic              unused_rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      en_q   <= 1'b0;
    end else begin
      if (cfg_wr) ctrl_q <= cfg_wdata;
      if (en_wr)  en_q   <= en_wdata;
    end
  end

  assign unused_rsvd = ^ctrl_q[SS_LO-1:DIV_LO+DIV_W];
  assign enable      = en_q;
  assign master      = ctrl_q[B_MASTER];
  assign pol         = ctrl_q[B_POL];
  assign pha         = ctrl_q[B_PHA];
  assign div_code    = ctrl_q[DIV_LO +: DIV_W];
  assign ss_field    = ctrl_q[SS_LO +: SS_N];
  assign hold_ss     = ctrl_q[B_HOLD_SS];
  assign gated_start = ctrl_q[B_GATED];
endmodule

// File: rtl/spi_clk_gen.sv
module spi_clk_gen
  import spi_ctl_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             master,
  input  logic             pol,
  input  logic             pha,
  input  logic [DIV_W-1:0] div_code,
  input  logic             gated_start,
  input  logic             tx_ready,
  input  logic             man_go,
  output logic             sclk,
  output logic             busy,
  output logic             word_done,
  output logic             sample_stb,
  output logic             shift_stb
);
  localparam int EDGES = 2 * WORD_BITS;
  localparam int EW    = $clog2(EDGES);

  logic              busy_q, sclk_q, done_q, smp_q, shf_q, pha_q;
  logic [HALF_W-1:0] cnt_q, half_q;
  logic [EW-1:0]     edge_q;
  logic              start_ok, half_end, last_edge, lead_edge;

  assign start_ok  = !busy_q && enable && master && tx_ready && (!gated_start || man_go);
  assign half_end  = (cnt_q == half_q - HALF_W'(1));
  assign last_edge = (edge_q == EW'(EDGES - 1));
  assign lead_edge = !edge_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
      smp_q  <= 1'b0; shf_q  <= 1'b0; pha_q  <= 1'b0;
      cnt_q  <= '0;   half_q <= HALF_W'(1); edge_q <= '0;
    end else begin
      smp_q  <= 1'b0;
      shf_q  <= 1'b0;
      done_q <= 1'b0;
      if (!enable) begin
        busy_q <= 1'b0;
        sclk_q <= pol;
      end else if (!busy_q) begin
        sclk_q <= pol;
        if (start_ok) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          edge_q <= '0;
          half_q <= half_cycles(div_code);
          pha_q  <= pha;
        end
      end else if (half_end) begin
        cnt_q  <= '0;
        sclk_q <= !sclk_q;
        edge_q <= edge_q + EW'(1);
        smp_q  <= lead_edge ^ pha_q;
        shf_q  <= !(lead_edge ^ pha_q);
        if (last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end
  end

  assign sclk       = sclk_q;
  assign busy       = busy_q;
  assign word_done  = done_q;
  assign sample_stb = smp_q;
  assign shift_stb  = shf_q;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_q && shf_q));
  // R4
  strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_q || shf_q) |-> (sclk_q != $past(sclk_q)));
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busy_q) |-> (sclk_q == $past(pol)));
  // R7
  off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy_q);
  // R2
  half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < half_q));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
endmodule

// File: rtl/spi_ss_drv.sv
module spi_ss_drv
  import spi_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_ss,
  input  logic            busy,
  input  logic [SS_N-1:0] ss_field,
  output logic [SS_N-1:0] ss_n
);
  logic drive;
  assign drive = hold_ss || busy;

  for (genvar i = 0; i < SS_N; i++) begin : g_line
    assign ss_n[i] = drive ? ss_field[i] : 1'b1;
  end

  // R5
  ss_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ss && !busy) |-> (ss_n == '1));
endmodule

// File: rtl/spi_sclk_cs_ctrl.sv
module spi_sclk_cs_ctrl
  import spi_ctl_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              en_wr,
  input  logic              en_wdata,
  input  logic              tx_ready,
  input  logic              man_go,
  output logic              sclk,
  output logic [SS_N-1:0]   ss_n,
  output logic              busy,
  output logic              word_done,
  output logic              sample_stb,
  output logic              shift_stb
);
  logic             enable, master, pol, pha, hold_ss, gated_start;
  logic [DIV_W-1:0] div_code;
  logic [SS_N-1:0]  ss_field;

  spi_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .en_wr(en_wr), .en_wdata(en_wdata), .enable(enable), .master(master),
    .pol(pol), .pha(pha), .div_code(div_code), .ss_field(ss_field),
    .hold_ss(hold_ss), .gated_start(gated_start)
  );

  spi_clk_gen #(.WORD_BITS(WORD_BITS)) u_clk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master(master), .pol(pol),
    .pha(pha), .div_code(div_code), .gated_start(gated_start),
    .tx_ready(tx_ready), .man_go(man_go), .sclk(sclk), .busy(busy),
    .word_done(word_done), .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  spi_ss_drv u_ss (
    .clk(clk), .rst_n(rst_n), .hold_ss(hold_ss), .busy(busy),
    .ss_field(ss_field), .ss_n(ss_n)
  );

  // R8
  slave_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !master) |=> !busy);
endmodule

// File: tb/test_spi_sclk_cs_ctrl.sv
module test_spi_sclk_cs_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, en_wr = 1'b0, en_wdata = 1'b0, tx_ready = 1'b0, man_go = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic sclk, busy, word_done, sample_stb, shift_stb;
  logic [3:0] ss_n;

  spi_sclk_cs_ctrl #(.WORD_BITS(W)) i_spi_sclk_cs_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .en_wr(en_wr), .en_wdata(en_wdata), .tx_ready(tx_ready), .man_go(man_go),
    .sclk(sclk), .ss_n(ss_n), .busy(busy), .word_done(word_done),
    .sample_stb(sample_stb), .shift_stb(shift_stb));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [15:0] m_ctrl = 16'h3C00;
  bit m_en = 0, m_busy = 0, m_sclk = 0, m_smp = 0, m_shf = 0, m_done = 0, m_pha = 0;
  int m_t = 0, m_half = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 16'h3C00; m_en = 0; m_busy = 0; m_sclk = 0;
      m_smp = 0; m_shf = 0; m_done = 0; m_t = 0; m_half = 1; m_pha = 0;
    end else begin
      m_smp = 0; m_shf = 0; m_done = 0;
      if (!m_en) begin
        m_busy = 0; m_sclk = m_ctrl[1];
      end else if (!m_busy) begin
        m_sclk = m_ctrl[1];
        if (m_ctrl[0] && tx_ready && (!m_ctrl[15] || man_go)) begin
          m_busy = 1; m_t = 0; m_half = 2 ** m_ctrl[5:3]; m_pha = m_ctrl[2];
        end
      end else begin
        m_t++;
        if (m_t % m_half == 0) begin
          int e;
          e = m_t / m_half - 1;
          m_sclk = !m_sclk;
          if (((e % 2) == 0) == (m_pha == 0)) m_smp = 1; else m_shf = 1;
          if (e == 2 * W - 1) begin m_busy = 0; m_done = 1; end
        end
      end
      if (cfg_wr) m_ctrl = cfg_wdata;
      if (en_wr)  m_en = en_wdata;
    end
  end

  int vec = 0, bad = 0, cyc = 0;
  bit fin = 0;
  string cur_req = "R1";

  task automatic chk(string sig, int act, int exp);
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h at cycle %0d", cur_req, sig, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] exp_ss;
    cyc++;
    if (!fin) begin
      exp_ss = (m_ctrl[14] || m_busy) ? m_ctrl[13:10] : 4'hF;
      vec++;
      chk("sclk", sclk, m_sclk);
      chk("ss_n", ss_n, exp_ss);
      chk("busy", busy, m_busy);
      chk("word_done", word_done, m_done);
      chk("sample_stb", sample_stb, m_smp);
      chk("shift_stb", shift_stb, m_shf);
      if (cyc > 150000) begin
        bad++;
        $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
        fin = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
      end
    end
  end

  function automatic logic [15:0] mk(bit mst, bit cpol, bit cpha, int dv,
                                     logic [3:0] ss, bit hold, bit gated);
    return {gated, hold, ss, 4'b0000, 3'(dv), cpha, cpol, mst};
  endfunction

  task automatic wr_cfg(logic [15:0] d);
    @(negedge clk); cfg_wr = 1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask
  task automatic wr_en(bit v);
    @(negedge clk); en_wr = 1; en_wdata = v;
    @(negedge clk); en_wr = 0;
  endtask
  task automatic pulse_ready();
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic one_word(int dv);
    pulse_ready();
    idle(2 * W * (2 ** dv) + 4);
  endtask

  initial begin
    cur_req = "R1"; idle(3); rst_n = 1; idle(5);
    wr_en(1);
    cur_req = "R2"; wr_cfg(mk(1, 0, 0, 0, 4'b1110, 0, 0)); one_word(0);
    cur_req = "R4"; wr_cfg(mk(1, 0, 1, 1, 4'b1101, 0, 0)); one_word(1);
    cur_req = "R3"; wr_cfg(mk(1, 1, 0, 2, 4'b1011, 0, 0)); idle(4); one_word(2);
    wr_cfg(mk(1, 1, 1, 1, 4'b0111, 0, 0)); one_word(1);
    cur_req = "R2"; wr_cfg(mk(1, 0, 0, 7, 4'b1110, 0, 0)); one_word(7);
    cur_req = "R6"; wr_cfg(mk(1, 0, 0, 1, 4'b1110, 0, 1));
    @(negedge clk); tx_ready = 1; idle(20);
    man_go = 1; @(negedge clk); man_go = 0; tx_ready = 0; idle(2 * W * 2 + 4);
    cur_req = "R8"; wr_cfg(mk(0, 0, 0, 0, 4'b1110, 0, 0));
    @(negedge clk); tx_ready = 1; idle(20); tx_ready = 0;
    cur_req = "R7"; wr_cfg(mk(1, 1, 0, 0, 4'b1110, 0, 0)); wr_en(0);
    @(negedge clk); tx_ready = 1; idle(20); tx_ready = 0;
    wr_en(1); wr_cfg(mk(1, 0, 0, 3, 4'b1110, 0, 0)); pulse_ready(); idle(30);
    wr_en(0); idle(10); wr_en(1);
    cur_req = "R9"; wr_cfg(mk(1, 0, 0, 1, 4'b1101, 0, 0));
    @(negedge clk); tx_ready = 1; idle(10);
    wr_cfg(mk(1, 0, 1, 0, 4'b1101, 0, 0)); idle(40);
    cur_req = "R10"; tx_ready = 0; idle(40);
    cur_req = "R5"; wr_cfg(mk(1, 0, 0, 0, 4'b1011, 1, 0)); idle(10);
    one_word(0); wr_cfg(mk(1, 0, 0, 0, 4'b1111, 1, 0)); idle(5);
    wr_cfg(mk(1, 0, 0, 0, 4'b0111, 0, 0)); idle(5); one_word(0);
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule